// File: doc/BRIEF.md
# Watchdog Down-Counter Timer

This block is a free-running 32-bit down-counter used as a general-purpose watchdog. It decrements at a fixed 5 MHz rate. A prescaler divides the system clock to produce a one-cycle tick enable at that rate. Software sees the count as two 16-bit halves. It can read either half at any time, and it can load either half with a write.

A control unit sends single-cycle pulses to start the timer, stop it, or apply a software reset. When the count steps down past zero, it reloads to all ones and keeps running. At the same time the block emits a one-cycle completion pulse, which downstream interrupt logic can latch and mask. Command decoding and interrupt masking live outside this block.

The prescaler restarts from zero on every write and every start. A write therefore always begins a full tick period.

Top module: `wdog_down_timer`

## Requirements
- R1: After `rst_n` is released, the count reads 0 in both halves, the timer is stopped, `expire_o` is low, and the count does not change until a start pulse arrives.
- R2: While running, the count drops by exactly one every DIV clock cycles (DIV = CLK_HZ / TICK_HZ). The first decrement lands DIV rising edges after the edge that samples the start pulse.
- R3: The 32-bit count is {high half, low half}. `rd_hi_i` = 1 selects bits 31:16 and 0 selects bits 15:0 on `rd_data_o`, combinationally from the live count. A borrow from the low half reaches the high half on the same tick.
- R4: A tick at count 0 loads 32'hFFFF_FFFF and counting continues. `expire_o` is high for exactly the one cycle following that edge.
- R5: A write with `wr_hi_i` = 1 loads bits 31:16 from `wr_data_i`, and with 0 loads bits 15:0. The other half is unchanged. The prescaler clears, so the next decrement comes DIV edges after the write edge.
- R6: A stop pulse freezes the count. A later start pulse resumes counting with a fresh tick period.
- R7: A software reset pulse stops the timer and keeps the current count.
- R8: When stop or software reset is sampled on the same edge as start, the timer ends up stopped.
- R9: On an edge that samples a write or any command pulse, no decrement happens. With a write, the new count is the old count with the written half replaced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-counting command pulse |
| stop_i | input | 1 | Stop-counting command pulse |
| srst_i | input | 1 | Software reset pulse; stops the timer |
| wr_en_i | input | 1 | Write strobe for one count half |
| wr_hi_i | input | 1 | Write half select: 1 high, 0 low |
| wr_data_i | input | HALF_W | Value written into the selected half |
| rd_hi_i | input | 1 | Read half select: 1 high, 0 low |
| rd_data_o | output | HALF_W | Selected half of the live count |
| expire_o | output | 1 | One-cycle pulse on wrap from zero to all ones |

## Verification
The bench builds the block with CLK_HZ = 20 MHz, which gives DIV = 4. A tick then arrives every four cycles, so each decrement, each prescaler restart and each wrap from zero can be placed on an exact edge within a few cycles.

At that rate, loading small counts brings the underflow reload and the expire pulse within reach. The bench also lines a write up with an edge where a tick would otherwise fall, to show the decrement is cancelled. Loading 32'h0001_0000 shows the borrow crossing from the low half into the high half.

// File: rtl/wdog_down_timer.sv
module wdog_down_timer #(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned TICK_HZ = 5_000_000,
  parameter int unsigned HALF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              srst_i,
  input  logic              wr_en_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wr_data_i,
  input  logic              rd_hi_i,
  output logic [HALF_W-1:0] rd_data_o,
  output logic              expire_o
);

  localparam int unsigned DIV   = (CLK_HZ / TICK_HZ) < 1 ? 1 : (CLK_HZ / TICK_HZ);
  localparam int unsigned PW    = DIV > 1 ? $clog2(DIV) : 1;
  localparam int unsigned CNT_W = 2 * HALF_W;
  localparam logic [PW-1:0] PLAST = PW'(DIV - 1);

  logic [PW-1:0]    presc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             expire_q;

  wire any_cmd = start_i | stop_i | srst_i;
  wire tick    = run_q && (presc_q == PLAST) && !wr_en_i && !any_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_q <= 1'b0;
    else if (srst_i || stop_i) run_q <= 1'b0;
    else if (start_i)          run_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   presc_q <= '0;
    else if (wr_en_i || any_cmd || !run_q)        presc_q <= '0;
    else if (presc_q == PLAST)                    presc_q <= '0;
    else                                          presc_q <= presc_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (wr_en_i) begin
      if (wr_hi_i)          cnt_q <= {wr_data_i, cnt_q[HALF_W-1:0]};
      else                  cnt_q <= {cnt_q[CNT_W-1:HALF_W], wr_data_i};
    end
    else if (tick)          cnt_q <= cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) expire_q <= 1'b0;
    else        expire_q <= tick && (cnt_q == '0);
  end

  assign expire_o  = expire_q;
  assign rd_data_o = rd_hi_i ? cnt_q[CNT_W-1:HALF_W] : cnt_q[HALF_W-1:0];

  AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    presc_q <= PLAST); // R2
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !wr_en_i) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CNT_W'(1))); // R2
  AST_FROZEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_en_i) |=> $stable(cnt_q)); // R6
  AST_WRAP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> (cnt_q == {CNT_W{1'b1}})); // R4
  AST_WRAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o); // R4
  AST_SRST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> !run_q); // R7
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && stop_i) |=> !run_q); // R8
  AST_WRITE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_hi_i) |=> (cnt_q[HALF_W-1:0] == $past(wr_data_i)
                               && cnt_q[CNT_W-1:HALF_W] == $past(cnt_q[CNT_W-1:HALF_W]))); // R5
  AST_WRITE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_hi_i) |=> (cnt_q[CNT_W-1:HALF_W] == $past(wr_data_i)
                              && cnt_q[HALF_W-1:0] == $past(cnt_q[HALF_W-1:0]))); // R9

endmodule

// File: tb/sim_wdog_down_timer.sv
`timescale 1ns/1ps
module sim_wdog_down_timer;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 0, stop_i = 0, srst_i = 0;
  logic        wr_en_i = 0, wr_hi_i = 0, rd_hi_i = 0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic        expire_o;

  int checks = 0, fails = 0, exp_seen = 0;

  wdog_down_timer #(.CLK_HZ(20_000_000), .TICK_HZ(5_000_000), .HALF_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .srst_i(srst_i),
    .wr_en_i(wr_en_i), .wr_hi_i(wr_hi_i), .wr_data_i(wr_data_i),
    .rd_hi_i(rd_hi_i), .rd_data_o(rd_data_o), .expire_o(expire_o));

  always #2.5 clk = ~clk;

  always @(negedge clk) if (rst_n && expire_o) exp_seen++;

  // {initial count, number of ticks}
  localparam logic [47:0] VEC [6] = '{
    {32'h0000_0010, 16'd5}, {32'h0001_0000, 16'd1}, {32'h0000_0002, 16'd4},
    {32'h0000_0000, 16'd1}, {32'hABCD_1234, 16'd7}, {32'h8000_0000, 16'd3}};

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(logic st, logic sp, logic sr);
    start_i = st; stop_i = sp; srst_i = sr;
    step(1);
    start_i = 0; stop_i = 0; srst_i = 0;
  endtask

  task automatic wr(logic hi, logic [15:0] d);
    wr_en_i = 1; wr_hi_i = hi; wr_data_i = d;
    step(1);
    wr_en_i = 0;
  endtask

  task automatic get(output logic [31:0] v);
    rd_hi_i = 0; #0.5; v[15:0]  = rd_data_o;
    rd_hi_i = 1; #0.5; v[31:16] = rd_data_o;
    rd_hi_i = 0;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_cnt(string req, logic [31:0] exp);
    logic [31:0] v;
    get(v);
    chk(req, v, exp);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R1: reset state and no counting without start
    chk_cnt("R1 reset count", 32'h0);
    chk("R1 expire low", {31'b0, expire_o}, 32'h0);
    step(5 * DIV);
    chk_cnt("R1 idle after reset", 32'h0);

    // R2 R3 R4: table walk
    for (int i = 0; i < 6; i++) begin
      logic [31:0] init;
      int n;
      init = VEC[i][47:16];
      n = int'(VEC[i][15:0]);
      wr(1'b1, init[31:16]);
      wr(1'b0, init[15:0]);
      exp_seen = 0;
      cmd(1, 0, 0);
      step(n * DIV);
      cmd(0, 1, 0);
      chk_cnt("R2 R3 count after ticks", init - 32'(n));
      chk("R4 expire pulses", 32'(exp_seen), (32'(n) > init) ? 32'd1 : 32'd0);
    end

    // R5: write while running restarts the period
    wr(1'b1, 16'h0000);
    wr(1'b0, 16'd100);
    cmd(1, 0, 0);
    step(2 * DIV + 2);
    wr(1'b0, 16'd50);
    step(DIV - 1);
    chk_cnt("R5 no tick before full period", 32'd50);
    step(1);
    chk_cnt("R5 tick one period after write", 32'd49);

    // R9: write on an edge where a tick would fall
    wr(1'b0, 16'd7);
    step(DIV - 1);
    wr(1'b1, 16'd2);
    chk_cnt("R9 write cancels tick", {16'd2, 16'd7});
    step(DIV - 1);
    chk_cnt("R9 still held", {16'd2, 16'd7});
    step(1);
    chk_cnt("R9 borrow-free tick", {16'd2, 16'd6});

    // R6: stop freezes, start resumes with fresh period
    cmd(0, 1, 0);
    step(3 * DIV);
    chk_cnt("R6 frozen after stop", {16'd2, 16'd6});
    cmd(1, 0, 0);
    step(DIV - 1);
    chk_cnt("R6 no tick before period", {16'd2, 16'd6});
    step(1);
    chk_cnt("R6 resumed", {16'd2, 16'd5});

    // R7: software reset stops and retains count
    cmd(0, 0, 1);
    step(3 * DIV);
    chk_cnt("R7 soft reset stops", {16'd2, 16'd5});

    // R8: conflicting commands leave it stopped
    cmd(1, 1, 0);
    step(3 * DIV);
    chk_cnt("R8 start+stop stays stopped", {16'd2, 16'd5});
    cmd(1, 0, 1);
    step(3 * DIV);
    chk_cnt("R8 start+srst stays stopped", {16'd2, 16'd5});

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule